// File: doc/BRIEF.md
# Read-Back Data Checker with First-Failure Capture

This block sits at the receive side of a memory test engine. A pattern source hands it the word it expects each read beat to carry. The block queues those words in a short first-in first-out buffer, so the expected stream may run ahead of the memory's returned data. Each returned beat is then paired with the oldest queued word and the two are compared.

Every comparison is reported one cycle later. The report gives the expected word, a valid strobe and a per-beat mismatch bit. A mismatch also sets a sticky error flag. The first mismatch freezes a wide status word. That word records the read command's start address and burst length, three controller queue flags, the expected word and the word actually read. Software or a test sequencer clears the flag and the status with a one-cycle clear pulse.

Top module: `readback_checker`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `cmpValid`, `cmpError`, `errFlag`, `cmpData` and `errStatus` are all zero.
- R2: Each cycle in which `expValid` is high queues `expData` behind the earlier words. The queue holds at most DEPTH words (default 4). A word offered while the queue is full is dropped.
- R3: A comparison happens in a cycle where `rdValid` is high and the queue held at least one word at the start of that cycle. The comparison consumes the oldest word. A `rdValid` beat that arrives while the queue is empty produces no report and does not touch the error flag.
- R4: In the cycle after a comparison, `cmpValid` is high and `cmpData` shows the expected word that was used. `cmpValid` is low in every other cycle.
- R5: In the cycle after a comparison, `cmpError` is high exactly when the expected word differed from `rdData`. `cmpError` is never high while `cmpValid` is low.
- R6: `errFlag` rises in the cycle after a mismatching comparison. It then stays high until a clear takes effect.
- R7: A mismatch seen while `errFlag` is low loads `errStatus` in the following cycle. The fields are taken from the comparison cycle: `cmdAddr` in [31:0], `cmdBlen` in [37:32], `cmdFull` in bit 40, `wrFull` in bit 41, `rdEmpty` in bit 42, the expected word in [64+DATA_W-1:64] and `rdData` in [64+2*DATA_W-1:64+DATA_W].
- R8: Further mismatches while `errFlag` is high leave `errStatus` unchanged.
- R9: A one-cycle `clearErr` pulse with no mismatch in that cycle returns `errFlag` and `errStatus` to zero in the next cycle.
- R10: If `clearErr` coincides with a mismatching comparison, then in the next cycle `errFlag` is high and `errStatus` holds the context of that new mismatch.
- R11: Bits [39:38] and [63:43] of `errStatus` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clearErr | input | 1 | Clears the sticky flag and the status word |
| expData | input | DATA_W | Expected word from the pattern source |
| expValid | input | 1 | Queues `expData` |
| rdData | input | DATA_W | Word returned by memory |
| rdValid | input | 1 | `rdData` is a valid read beat |
| cmdAddr | input | 32 | Start address of the read in flight |
| cmdBlen | input | 6 | Burst length of the read in flight |
| cmdFull | input | 1 | Controller command queue full |
| wrFull | input | 1 | Controller write queue full |
| rdEmpty | input | 1 | Controller read queue empty |
| cmpData | output | DATA_W | Expected word of the last comparison |
| cmpValid | output | 1 | Comparison report strobe |
| cmpError | output | 1 | Last comparison mismatched |
| errFlag | output | 1 | Sticky error flag |
| errStatus | output | 64+2*DATA_W | Context latched at the first mismatch |

## Verification
Error clearing and error capture can fall in the same cycle. The bench sets the flag with one mismatch, then presents a second mismatching beat in the cycle where it pulses `clearErr`. It then expects the flag to stay high and the status word to carry the second beat's address, burst length, flags and data, not zeros or the older context. Queue overflow and a read on an empty queue are also provoked. The bench holds `expValid` past capacity and then issues one read more than the queue can serve, so the surplus read must yield no report.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic push;     // write expected word into queue
    logic pop;      // consume oldest word and compare
    logic capture;  // load the status word
    logic clear;    // zero the status word
  } rbcStrobe_t;

  // Status word layout; positions are decoded by software
  localparam int ST_ADDR_LSB    = 0;
  localparam int ST_ADDR_W      = 32;
  localparam int ST_BLEN_LSB    = 32;
  localparam int ST_BLEN_W      = 6;
  localparam int ST_CMDFULL_BIT = 40;
  localparam int ST_WRFULL_BIT  = 41;
  localparam int ST_RDEMPTY_BIT = 42;
  localparam int ST_DATA_LSB    = 64;

endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             expValid,
  input  logic             rdValid,
  input  logic             clearErr,
  input  logic             mismatch,
  output rbcStrobe_t       strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             errFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic             qEmpty;
  logic             qFull;

  assign qEmpty = (count == '0);
  assign qFull  = (count == CNT_MAX);

  always_comb begin
    strb.push    = expValid && !qFull;
    strb.pop     = rdValid && !qEmpty;
    strb.clear   = clearErr;
    strb.capture = strb.pop && mismatch && (!errFlag || clearErr);
  end

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= advance(wrPtr);
      if (strb.pop)  rdPtr <= advance(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      errFlag <= 1'b0;
    else if (strb.pop && mismatch)  errFlag <= 1'b1;
    else if (clearErr)              errFlag <= 1'b0;
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_MAX);

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && expValid && !rdValid) |=> (count == CNT_MAX));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> $past(clearErr));

endmodule

// File: rtl/rbc_datapath.sv
module rbc_datapath
  import rbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int STAT_W = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rbcStrobe_t           strb,
  input  logic [PTR_W-1:0]     wrPtr,
  input  logic [PTR_W-1:0]     rdPtr,
  input  logic [DATA_W-1:0]    expData,
  input  logic [DATA_W-1:0]    rdData,
  input  logic [ST_ADDR_W-1:0] cmdAddr,
  input  logic [ST_BLEN_W-1:0] cmdBlen,
  input  logic                 cmdFull,
  input  logic                 wrFull,
  input  logic                 rdEmpty,
  output logic                 mismatch,
  output logic [DATA_W-1:0]    cmpData,
  output logic                 cmpValid,
  output logic                 cmpError,
  output logic [STAT_W-1:0]    errStatus
);

  localparam int RD_LSB = ST_DATA_LSB + DATA_W;

  logic [DATA_W-1:0] qMem [DEPTH];
  logic [DATA_W-1:0] headWord;
  logic [STAT_W-1:0] statusNext;

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strb.push && (wrPtr == PTR_W'(e))) qMem[e] <= expData;
    end
  end

  assign headWord = qMem[rdPtr];
  assign mismatch = (headWord != rdData);

  always_comb begin
    statusNext = '0;
    statusNext[ST_ADDR_LSB +: ST_ADDR_W] = cmdAddr;
    statusNext[ST_BLEN_LSB +: ST_BLEN_W] = cmdBlen;
    statusNext[ST_CMDFULL_BIT]           = cmdFull;
    statusNext[ST_WRFULL_BIT]            = wrFull;
    statusNext[ST_RDEMPTY_BIT]           = rdEmpty;
    statusNext[ST_DATA_LSB +: DATA_W]    = headWord;
    statusNext[RD_LSB +: DATA_W]         = rdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpError <= 1'b0;
      cmpData  <= '0;
    end else begin
      cmpValid <= strb.pop;
      cmpError <= strb.pop && mismatch;
      if (strb.pop) cmpData <= headWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             errStatus <= '0;
    else if (strb.capture) errStatus <= statusNext;
    else if (strb.clear)   errStatus <= '0;
  end

  assert_error_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmpError |-> cmpValid);

  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.capture) && !$past(strb.clear)) |-> $stable(errStatus));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (errStatus[39:38] == 2'b00) && (errStatus[63:43] == '0));

  assert_report_follows_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> cmpValid);

endmodule

// File: rtl/readback_checker.sv
module readback_checker
  import rbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int STAT_W = ST_DATA_LSB + 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearErr,
  input  logic [DATA_W-1:0]    expData,
  input  logic                 expValid,
  input  logic [DATA_W-1:0]    rdData,
  input  logic                 rdValid,
  input  logic [ST_ADDR_W-1:0] cmdAddr,
  input  logic [ST_BLEN_W-1:0] cmdBlen,
  input  logic                 cmdFull,
  input  logic                 wrFull,
  input  logic                 rdEmpty,
  output logic [DATA_W-1:0]    cmpData,
  output logic                 cmpValid,
  output logic                 cmpError,
  output logic                 errFlag,
  output logic [STAT_W-1:0]    errStatus
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rbcStrobe_t       strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             mismatch;

  rbc_ctrl #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .expValid (expValid),
    .rdValid  (rdValid),
    .clearErr (clearErr),
    .mismatch (mismatch),
    .strb     (strb),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .errFlag  (errFlag)
  );

  rbc_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .PTR_W  (PTR_W),
    .STAT_W (STAT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .expData   (expData),
    .rdData    (rdData),
    .cmdAddr   (cmdAddr),
    .cmdBlen   (cmdBlen),
    .cmdFull   (cmdFull),
    .wrFull    (wrFull),
    .rdEmpty   (rdEmpty),
    .mismatch  (mismatch),
    .cmpData   (cmpData),
    .cmpValid  (cmpValid),
    .cmpError  (cmpError),
    .errStatus (errStatus)
  );

  assert_valid_after_reset_R1: assert property (@(posedge clk)
    !rstN |=> !cmpValid && !errFlag);

endmodule

// File: tb/readback_checker_tb.sv
module readback_checker_tb;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int STAT_W = 64 + 2 * DATA_W;
  localparam int NVEC   = 8;

  localparam logic [DATA_W-1:0] VEC_EXP [NVEC] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5678,
    32'h8000_0001, 32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h7654_3210};
  localparam logic [DATA_W-1:0] VEC_RD [NVEC] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5679,
    32'h8000_0001, 32'hDEAD_BEEE, 32'h0F0F_F0F0, 32'h0000_0000};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clearErr = 1'b0;
  logic [DATA_W-1:0] expData = '0;
  logic              expValid = 1'b0;
  logic [DATA_W-1:0] rdData = '0;
  logic              rdValid = 1'b0;
  logic [31:0]       cmdAddr = '0;
  logic [5:0]        cmdBlen = '0;
  logic              cmdFull = 1'b0;
  logic              wrFull = 1'b0;
  logic              rdEmpty = 1'b0;
  logic [DATA_W-1:0] cmpData;
  logic              cmpValid;
  logic              cmpError;
  logic              errFlag;
  logic [STAT_W-1:0] errStatus;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic              mFlag = 1'b0;
  logic [STAT_W-1:0] mStatus = '0;

  always #2 clk = ~clk;

  readback_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .clearErr(clearErr),
    .expData(expData), .expValid(expValid),
    .rdData(rdData), .rdValid(rdValid),
    .cmdAddr(cmdAddr), .cmdBlen(cmdBlen),
    .cmdFull(cmdFull), .wrFull(wrFull), .rdEmpty(rdEmpty),
    .cmpData(cmpData), .cmpValid(cmpValid), .cmpError(cmpError),
    .errFlag(errFlag), .errStatus(errStatus));

  task automatic check(input bit ok, input string tag,
                       input logic [STAT_W-1:0] act, input logic [STAT_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [STAT_W-1:0] buildStatus(
      input logic [31:0] a, input logic [5:0] b, input logic [2:0] f,
      input logic [DATA_W-1:0] e, input logic [DATA_W-1:0] r);
    logic [STAT_W-1:0] s;
    s = '0;
    s[31:0]  = a;
    s[37:32] = b;
    s[40]    = f[0];
    s[41]    = f[1];
    s[42]    = f[2];
    s[64 +: DATA_W]          = e;
    s[64 + DATA_W +: DATA_W] = r;
    return s;
  endfunction

  task automatic pushWord(input logic [DATA_W-1:0] w);
    expValid = 1'b1;
    expData  = w;
    tick();
    expValid = 1'b0;
  endtask

  // One read beat against a known queued word, with the model updated per R5..R10
  task automatic doCompare(input logic [DATA_W-1:0] e, input logic [DATA_W-1:0] r,
                           input logic [31:0] a, input logic [5:0] b,
                           input logic [2:0] f, input bit clr, input string tag);
    bit mis;
    mis = (e != r);
    rdValid = 1'b1; rdData = r; cmdAddr = a; cmdBlen = b;
    cmdFull = f[0]; wrFull = f[1]; rdEmpty = f[2]; clearErr = clr;
    tick();
    rdValid = 1'b0; clearErr = 1'b0;
    if (mis && (!mFlag || clr)) mStatus = buildStatus(a, b, f, e, r);
    else if (clr)               mStatus = '0;
    if (mis)      mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    check(cmpValid == 1'b1, {tag, " R4 cmpValid"}, STAT_W'(cmpValid), 1);
    check(cmpData == e, {tag, " R4 cmpData"}, STAT_W'(cmpData), STAT_W'(e));
    check(cmpError == mis, {tag, " R5 cmpError"}, STAT_W'(cmpError), STAT_W'(mis));
    check(errFlag == mFlag, {tag, " R6 errFlag"}, STAT_W'(errFlag), STAT_W'(mFlag));
    check(errStatus == mStatus, {tag, " R7 R8 errStatus"}, errStatus, mStatus);
    check(errStatus[63:43] == '0 && errStatus[39:38] == '0, {tag, " R11 reserved"},
          errStatus, mStatus);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check(cmpValid == 0 && cmpError == 0 && errFlag == 0, "R1 strobes in reset",
          {cmpValid, cmpError, errFlag}, 0);
    check(errStatus == '0 && cmpData == '0, "R1 data in reset", errStatus, 0);
    rstN = 1'b1;
    tick();
    check(cmpValid == 0 && errFlag == 0 && errStatus == '0, "R1 after release",
          errStatus, 0);

    // R3: read beat with empty queue is ignored
    rdValid = 1'b1; rdData = 32'hBAD0_0BAD;
    tick();
    rdValid = 1'b0;
    check(cmpValid == 0, "R3 empty read no report", STAT_W'(cmpValid), 0);
    check(errFlag == 0 && errStatus == '0, "R3 empty read no error", errStatus, 0);

    // Vector table walk: matches, first mismatch capture (R7), later mismatches (R8)
    for (int i = 0; i < NVEC; i++) begin
      pushWord(VEC_EXP[i]);
      doCompare(VEC_EXP[i], VEC_RD[i], 32'h1000_0000 + 32'(i * 64), 6'(i + 1),
                3'(i), 1'b0, $sformatf("vec%0d", i));
    end
    tick();
    check(cmpValid == 0, "R4 strobe single cycle", STAT_W'(cmpValid), 0);
    check(errFlag == 1, "R6 flag held while idle", STAT_W'(errFlag), 1);

    // R9: clear pulse
    clearErr = 1'b1;
    tick();
    clearErr = 1'b0;
    mFlag = 1'b0; mStatus = '0;
    check(errFlag == 0, "R9 flag cleared", STAT_W'(errFlag), 0);
    check(errStatus == '0, "R9 status cleared", errStatus, 0);

    // R2: order preserved over several queued words
    pushWord(32'h0000_0011);
    pushWord(32'h0000_0022);
    pushWord(32'h0000_0033);
    doCompare(32'h0000_0011, 32'h0000_0011, 32'h20, 6'd2, 3'd0, 1'b0, "R2 order0");
    doCompare(32'h0000_0022, 32'h0000_0022, 32'h24, 6'd2, 3'd0, 1'b0, "R2 order1");
    doCompare(32'h0000_0033, 32'h0000_0033, 32'h28, 6'd2, 3'd0, 1'b0, "R2 order2");

    // R2: overflow drops words beyond DEPTH
    for (int k = 0; k < DEPTH + 2; k++) pushWord(32'h0000_0100 + 32'(k));
    for (int k = 0; k < DEPTH; k++)
      doCompare(32'h0000_0100 + 32'(k), 32'h0000_0100 + 32'(k), 32'h40, 6'd4, 3'd0,
                1'b0, $sformatf("R2 ovf%0d", k));
    rdValid = 1'b1; rdData = 32'h0000_0104;
    tick();
    rdValid = 1'b0;
    check(cmpValid == 0, "R2 dropped word not queued", STAT_W'(cmpValid), 0);
    check(errFlag == 0, "R3 surplus read no error", STAT_W'(errFlag), 0);

    // R10: clear and mismatch in the same cycle
    pushWord(32'hCAFE_0001);
    doCompare(32'hCAFE_0001, 32'hCAFE_0000, 32'h0000_0AA0, 6'd7, 3'b001, 1'b0, "R10 setup");
    pushWord(32'hCAFE_0002);
    doCompare(32'hCAFE_0002, 32'h0000_0002, 32'h0000_0BB0, 6'd33, 3'b110, 1'b1, "R10 clr+mis");
    check(errStatus[31:0] == 32'h0000_0BB0, "R10 new address", errStatus[31:0], 32'hBB0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule